// File: doc/BRIEF.md
# Fixed-Block Cache Operation Sequencer

This block takes one fixed-size cache maintenance operation that has already been decoded, along with a base register value and a signed 12-bit offset. It forms the effective address the same way an ordinary load or store does, aligns that address down to the operation's block size, and then issues one or more 64-byte line requests toward the data cache controller. Each request uses a ready/valid handshake.

There are two families of operation, and each has its own request port:

- **Prefetches** (read intent or write intent) go out on the load-side port. They produce no register result.
- **Push-outs** (clean or flush) go out on the store-side port. They behave like uncombined, non-serializing stores.
  - A clean writes dirty data back and leaves a valid clean copy.
  - A flush writes dirty data back and then invalidates the line, whether or not it was dirty.
  - A level select chooses between the L1 data cache (pushing into L2) and L2 itself. The L1 level touches only the data cache, never the instruction cache.

A 256-byte operation becomes four line requests issued in ascending address order. While that expansion runs, the sequencer holds off new input. A block size the hardware does not support retires quietly with no request issued. Every operation ends with a one-cycle done pulse.

Top module: `cmo_block_seq`

## Requirements
- R1: The effective address is `op_base + sign_extend(op_offset)` modulo 2^32. The first line request carries this address aligned down to the block size.
- R2: An operation with size code 0 (64 bytes) issues exactly one line request, at the effective address with its low 6 bits cleared.
- R3: An operation with size code 1 (256 bytes) issues exactly four line requests. The first is at the effective address with its low 8 bits cleared, and each following one is 64 bytes higher.
- R4: Kind codes 0 (prefetch for read) and 1 (prefetch for write) raise only `ld_valid`, with `ld_kind` equal to the input kind and `ld_level` forced to 0. `st_valid` stays low for these kinds.
- R5: Kind codes 2 (clean) and 3 (flush) raise only `st_valid`, with `st_kind` equal to the input kind. `st_level` equals `op_level` (0 = L1 data cache into L2, 1 = out of L2). `ld_valid` stays low for these kinds.
- R6: Size codes 2 and 3, and kind codes 4 to 7, issue no request on either port. For such an operation `done` rises for one cycle, in the cycle after acceptance.
- R7: `op_ready` is high whenever no line requests are pending. It is low from the cycle after a request-issuing operation is accepted until the cycle after its last line handshake.
- R8: While a request is valid and not yet accepted, its valid, address, kind and level hold steady.
- R9: `done` is high for exactly the one cycle that follows the handshake of the operation's last line.
- R10: After reset, `op_ready` is high and `ld_valid`, `st_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer can accept an operation |
| op_kind | input | 3 | 0 prefetch-read, 1 prefetch-write, 2 clean, 3 flush, others no-op |
| op_size | input | 2 | 0 = 64 B, 1 = 256 B, 2 and 3 unsupported |
| op_level | input | 1 | Push-out target level |
| op_base | input | 32 | Base register value |
| op_offset | input | 12 | Signed immediate offset |
| ld_valid | output | 1 | Load-side line request valid |
| ld_ready | input | 1 | Load-side request accepted |
| ld_addr | output | 32 | Load-side line address |
| ld_kind | output | 3 | Load-side operation kind |
| ld_level | output | 1 | Load-side level (always 0) |
| st_valid | output | 1 | Store-side line request valid |
| st_ready | input | 1 | Store-side request accepted |
| st_addr | output | 32 | Store-side line address |
| st_kind | output | 3 | Store-side operation kind |
| st_level | output | 1 | Store-side target level |
| done | output | 1 | Operation retired pulse |

## Verification
The bench sweeps every kind, size and level code across offsets that carry into, borrow from and wrap the base. It targets the following faults:

- **Wrong extension of the offset.** A design that zero-extends it would place negative-offset requests 4 KiB too high.
- **Wrong alignment.** A design that aligns 256-byte blocks to 64 bytes would start mid-block.
- **Wrong line count or step.** These faults show up as missing, extra or repeated line addresses.

The bench also stalls the ready signal every few cycles. A design that advanced or changed the address without a handshake would then skip lines. Misrouted operations appear on the wrong port. Unsupported codes that leak a request, or a done pulse that is mistimed, also fail.

// File: rtl/cmo_seq_pkg.sv
// Shared encodings for the fixed-block cache operation sequencer.
// Assumes the kind and size codes listed in the brief; other values are no-ops.
package cmo_seq_pkg;

    localparam logic [2:0] KIND_PF_RD = 3'd0;
    localparam logic [2:0] KIND_PF_WR = 3'd1;
    localparam logic [2:0] KIND_CLEAN = 3'd2;
    localparam logic [2:0] KIND_FLUSH = 3'd3;

    localparam logic [1:0] SIZE_LINE  = 2'd0;
    localparam logic [1:0] SIZE_BLOCK = 2'd1;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_e;

    function automatic logic kind_is_prefetch(input logic [2:0] k);
        return (k == KIND_PF_RD) || (k == KIND_PF_WR);
    endfunction

    function automatic logic kind_is_pushout(input logic [2:0] k);
        return (k == KIND_CLEAN) || (k == KIND_FLUSH);
    endfunction

endpackage

// File: rtl/cmo_addr_gen.sv
// Effective address and block alignment.
// Forms base plus sign-extended 12-bit offset, then clears the low bits
// for either a single line or a multi-line block. Purely combinational.
module cmo_addr_gen #(
    parameter int AW      = 32,
    parameter int LINE_LG = 6,
    parameter int BLK_LG  = 8
) (
    input  logic [AW-1:0] base,
    input  logic [11:0]   offset,
    input  logic          big_block,
    output logic [AW-1:0] start_addr
);
    localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << LINE_LG) - AW'(1));
    localparam logic [AW-1:0] BLK_MASK  = ~((AW'(1) << BLK_LG) - AW'(1));

    logic [AW-1:0] eff_addr;

    // Sum base and sign-extended offset, then align to the selected block size.
    always_comb begin
        eff_addr   = base + {{(AW-12){offset[11]}}, offset};
        start_addr = eff_addr & (big_block ? BLK_MASK : LINE_MASK);
    end
endmodule

// File: rtl/cmo_op_plan.sv
// Classifies an operation: number of line requests, which port, effective level.
// Assumes kinds 0..3 are valid and sizes 0/1 are the only supported ones;
// SUPPORT_BIG = 0 turns the multi-line size into a no-op as well.
module cmo_op_plan
    import cmo_seq_pkg::*;
#(
    parameter int BLK_LINES   = 4,
    parameter int CNT_W       = 3,
    parameter bit SUPPORT_BIG = 1'b1
) (
    input  logic [2:0]       kind,
    input  logic [1:0]       size,
    input  logic             level,
    output logic             noop,
    output logic             to_load,
    output logic             eff_level,
    output logic             big_block,
    output logic [CNT_W-1:0] n_lines
);
    logic big_ok;

    // Pick whether the multi-line size is implemented.
    generate
        if (SUPPORT_BIG) begin : g_big
            assign big_ok = 1'b1;
        end else begin : g_nobig
            assign big_ok = 1'b0;
        end
    endgenerate

    // Decide line count, routing and level for the offered operation.
    always_comb begin
        to_load   = kind_is_prefetch(kind);
        eff_level = to_load ? 1'b0 : level;
        big_block = (size == SIZE_BLOCK);
        if (!(kind_is_prefetch(kind) || kind_is_pushout(kind))) begin
            noop    = 1'b1;
            n_lines = CNT_W'(1);
        end else if (size == SIZE_LINE) begin
            noop    = 1'b0;
            n_lines = CNT_W'(1);
        end else if (big_block && big_ok) begin
            noop    = 1'b0;
            n_lines = CNT_W'(BLK_LINES);
        end else begin
            noop    = 1'b1;
            n_lines = CNT_W'(1);
        end
    end
endmodule

// File: rtl/cmo_line_fsm.sv
// Line issue sequencer: captures one accepted operation and steps through
// its line addresses, one request per handshake, then pulses done.
// Assumes the downstream holds its ready meaning per cycle (standard ready/valid).
module cmo_line_fsm
    import cmo_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LINE_LG = 6,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_noop,
    input  logic [AW-1:0]    in_addr,
    input  logic [CNT_W-1:0] in_lines,
    input  logic [2:0]       in_kind,
    input  logic             in_level,
    input  logic             in_to_load,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [AW-1:0]    req_addr,
    output logic [2:0]       req_kind,
    output logic             req_level,
    output logic             req_to_load,
    output logic             done
);
    localparam logic [AW-1:0] LINE_STEP = AW'(1) << LINE_LG;

    seq_state_e       state_q;
    logic [CNT_W-1:0] left_q;
    logic             accept;
    logic             fire;
    logic             last;

    // Handshake decode for input and output sides.
    always_comb begin
        in_ready  = (state_q == SEQ_IDLE);
        req_valid = (state_q == SEQ_ISSUE);
        accept    = in_valid && in_ready;
        fire      = req_valid && req_ready;
        last      = (left_q == '0);
    end

    // State, line address, remaining count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            left_q      <= '0;
            req_addr    <= '0;
            req_kind    <= '0;
            req_level   <= 1'b0;
            req_to_load <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        if (in_noop) begin
                            done <= 1'b1;
                        end else begin
                            state_q     <= SEQ_ISSUE;
                            req_addr    <= in_addr;
                            left_q      <= in_lines - CNT_W'(1);
                            req_kind    <= in_kind;
                            req_level   <= in_level;
                            req_to_load <= in_to_load;
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        if (last) begin
                            state_q <= SEQ_IDLE;
                            done    <= 1'b1;
                        end else begin
                            req_addr <= req_addr + LINE_STEP;
                            left_q   <= left_q - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R8: a stalled request keeps its contents.
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_kind) && $stable(req_level));

    // R3: successive lines of one block step up by one line.
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last |=> req_valid && (req_addr == $past(req_addr) + LINE_STEP));

    // R2: every issued address is line aligned.
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[LINE_LG-1:0] == '0));

    // R9 / R6: done only follows a final handshake or a no-op acceptance.
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fire && last) || $past(accept && in_noop));

    // R7: no new operation is taken while lines are still pending.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last |=> !in_ready);
endmodule

// File: rtl/cmo_port_route.sv
// Steers the single internal request onto the load-side or store-side port
// and returns the matching ready. Combinational.
module cmo_port_route
    import cmo_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_kind,
    input  logic          req_level,
    input  logic          req_to_load,
    output logic          ld_valid,
    input  logic          ld_ready,
    output logic [AW-1:0] ld_addr,
    output logic [2:0]    ld_kind,
    output logic          ld_level,
    output logic          st_valid,
    input  logic          st_ready,
    output logic [AW-1:0] st_addr,
    output logic [2:0]    st_kind,
    output logic          st_level
);
    // Demultiplex valid and payload, multiplex ready.
    always_comb begin
        ld_valid  = req_valid && req_to_load;
        st_valid  = req_valid && !req_to_load;
        ld_addr   = req_addr;
        st_addr   = req_addr;
        ld_kind   = req_kind;
        st_kind   = req_kind;
        ld_level  = 1'b0;
        st_level  = req_level;
        req_ready = req_to_load ? ld_ready : st_ready;
    end

    // R4 / R5: never both ports at once.
    a_r4_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && st_valid));

    // R4: only prefetch kinds appear on the load side.
    a_r4_load_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> kind_is_prefetch(ld_kind));

    // R5: only push-out kinds appear on the store side.
    a_r5_store_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> kind_is_pushout(st_kind));
endmodule

// File: rtl/cmo_block_seq.sv
// Top of the fixed-block cache operation sequencer.
// Accepts one decoded operation, expands it into aligned 64-byte line
// requests on the load or store port, and pulses done when it retires.
// Assumes a line of LINE_BYTES and one larger block of BLOCK_BYTES.
module cmo_block_seq #(
    parameter int AW          = 32,
    parameter int LINE_BYTES  = 64,
    parameter int BLOCK_BYTES = 256,
    parameter bit SUPPORT_BIG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [2:0]    op_kind,
    input  logic [1:0]    op_size,
    input  logic          op_level,
    input  logic [AW-1:0] op_base,
    input  logic [11:0]   op_offset,
    output logic          ld_valid,
    input  logic          ld_ready,
    output logic [AW-1:0] ld_addr,
    output logic [2:0]    ld_kind,
    output logic          ld_level,
    output logic          st_valid,
    input  logic          st_ready,
    output logic [AW-1:0] st_addr,
    output logic [2:0]    st_kind,
    output logic          st_level,
    output logic          done
);
    localparam int LINE_LG   = $clog2(LINE_BYTES);
    localparam int BLK_LG    = $clog2(BLOCK_BYTES);
    localparam int BLK_LINES = BLOCK_BYTES / LINE_BYTES;
    localparam int CNT_W     = $clog2(BLK_LINES) + 1;

    logic             p_noop, p_to_load, p_level, p_big;
    logic [CNT_W-1:0] p_lines;
    logic [AW-1:0]    p_addr;
    logic             r_valid, r_ready, r_level, r_to_load;
    logic [AW-1:0]    r_addr;
    logic [2:0]       r_kind;

    cmo_op_plan #(.BLK_LINES(BLK_LINES), .CNT_W(CNT_W), .SUPPORT_BIG(SUPPORT_BIG)) u_plan (
        .kind(op_kind), .size(op_size), .level(op_level),
        .noop(p_noop), .to_load(p_to_load), .eff_level(p_level),
        .big_block(p_big), .n_lines(p_lines)
    );

    cmo_addr_gen #(.AW(AW), .LINE_LG(LINE_LG), .BLK_LG(BLK_LG)) u_agen (
        .base(op_base), .offset(op_offset), .big_block(p_big), .start_addr(p_addr)
    );

    cmo_line_fsm #(.AW(AW), .LINE_LG(LINE_LG), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(op_valid), .in_ready(op_ready), .in_noop(p_noop),
        .in_addr(p_addr), .in_lines(p_lines), .in_kind(op_kind),
        .in_level(p_level), .in_to_load(p_to_load),
        .req_valid(r_valid), .req_ready(r_ready), .req_addr(r_addr),
        .req_kind(r_kind), .req_level(r_level), .req_to_load(r_to_load),
        .done(done)
    );

    cmo_port_route #(.AW(AW)) u_route (
        .clk(clk), .rst_n(rst_n),
        .req_valid(r_valid), .req_ready(r_ready), .req_addr(r_addr),
        .req_kind(r_kind), .req_level(r_level), .req_to_load(r_to_load),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_kind(ld_kind), .ld_level(ld_level),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_kind(st_kind), .st_level(st_level)
    );

    // R10: out of reset nothing is pending.
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> op_ready && !ld_valid && !st_valid && !done);
endmodule

// File: tb/test_cmo_block_seq.sv
// Sweeps all kind/size/level codes over several address patterns and two
// ready patterns, checking every line request and the done pulse.
module test_cmo_block_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [2:0]  op_kind = '0;
    logic [1:0]  op_size = '0;
    logic        op_level = 1'b0;
    logic [31:0] op_base = '0;
    logic [11:0] op_offset = '0;
    logic        ld_valid, ld_ready = 1'b0, ld_level;
    logic [31:0] ld_addr;
    logic [2:0]  ld_kind;
    logic        st_valid, st_ready = 1'b0, st_level;
    logic [31:0] st_addr;
    logic [2:0]  st_kind;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;  // 50 MHz

    cmo_block_seq i_cmo_block_seq (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_size(op_size), .op_level(op_level), .op_base(op_base),
        .op_offset(op_offset),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_kind(ld_kind), .ld_level(ld_level),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_kind(st_kind), .st_level(st_level), .done(done)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Runs one operation end to end; stall=1 grants ready one cycle in three.
    task automatic run_op(input logic [2:0] k, input logic [1:0] s, input logic lv,
                          input logic [31:0] b, input logic [11:0] off, input bit stall);
        logic [31:0] ea, start;
        int n;
        bit is_ld;
        int i;
        int tick;
        ea = b + {{20{off[11]}}, off};
        if (k <= 3 && s == 0)      n = 1;
        else if (k <= 3 && s == 1) n = 4;
        else                       n = 0;
        start = (s == 1) ? (ea & 32'hFFFF_FF00) : (ea & 32'hFFFF_FFC0);
        is_ld = (k <= 1);
        @(negedge clk);
        chk(op_ready == 1'b1, "R7 idle ready", 32'(op_ready), 1);
        op_valid = 1'b1; op_kind = k; op_size = s; op_level = lv;
        op_base = b; op_offset = off;
        @(negedge clk);
        op_valid = 1'b0;
        if (n == 0) begin
            chk(!ld_valid && !st_valid, "R6 no request", {30'd0, ld_valid, st_valid}, 0);
            chk(done == 1'b1, "R6 done after accept", 32'(done), 1);
            @(negedge clk);
            chk(done == 1'b0, "R6 done single", 32'(done), 0);
            return;
        end
        i = 0;
        tick = 0;
        while (i < n) begin
            chk(op_ready == 1'b0, "R7 busy", 32'(op_ready), 0);
            chk(done == 1'b0, "R9 no early done", 32'(done), 0);
            if (is_ld) begin
                chk(ld_valid && !st_valid, "R4 load port", {30'd0, ld_valid, st_valid}, 2);
                chk(ld_addr == start + 32'(64 * i), (s == 1) ? "R3 block addr" : "R1 R2 line addr",
                    ld_addr, start + 32'(64 * i));
                chk(ld_kind == k && ld_level == 1'b0, "R4 kind/level",
                    {28'd0, ld_kind, ld_level}, {28'd0, k, 1'b0});
            end else begin
                chk(st_valid && !ld_valid, "R5 store port", {30'd0, ld_valid, st_valid}, 1);
                chk(st_addr == start + 32'(64 * i), (s == 1) ? "R3 block addr" : "R1 R2 line addr",
                    st_addr, start + 32'(64 * i));
                chk(st_kind == k && st_level == lv, "R5 kind/level",
                    {28'd0, st_kind, st_level}, {28'd0, k, lv});
            end
            ld_ready = !stall || (tick % 3 == 2);
            st_ready = ld_ready;
            tick++;
            @(negedge clk);
            if (ld_ready) i++;
            else chk(ld_valid || st_valid, "R8 held while stalled", 0, 1);
        end
        ld_ready = 1'b0; st_ready = 1'b0;
        chk(done == 1'b1, "R9 done after last", 32'(done), 1);
        chk(!ld_valid && !st_valid, "R3 no extra line", {30'd0, ld_valid, st_valid}, 0);
        chk(op_ready == 1'b1, "R7 ready after last", 32'(op_ready), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single", 32'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] bases [4];
        logic [11:0] offs [4];
        bases[0] = 32'h0000_1000; offs[0] = 12'h000;
        bases[1] = 32'h8000_0FC4; offs[1] = 12'h7FF;
        bases[2] = 32'h0000_0010; offs[2] = 12'h800;
        bases[3] = 32'h1234_5678; offs[3] = 12'hFD1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready && !ld_valid && !st_valid && !done, "R10 reset state",
            {28'd0, op_ready, ld_valid, st_valid, done}, 32'h8);
        for (int st = 0; st < 2; st++)
            for (int a = 0; a < 4; a++)
                for (int k = 0; k < 8; k++)
                    for (int s = 0; s < 4; s++)
                        for (int lv = 0; lv < 2; lv++)
                            run_op(3'(k), 2'(s), 1'(lv), bases[a], offs[a], st[0]);
        finish_run();
    end
endmodule